// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI controller from the controller's input clock. A single 32-bit configuration word sets the timing. The word carries a period count and a separate high count, so the SCLK period and its high time are set independently rather than through one divide ratio with a fixed 50% duty. It also carries a divider value that supplies a near-square default when the period count is left at zero, and a clock-source select bit that the block passes outward unchanged. A shift engine beside this block uses two single-cycle strobes, one at each SCLK edge, to launch and capture data. SCLK stays low whenever no transfer is running.

The configuration word may be written at any time. The block uses the word as it stood while `run` was last sampled low, so a write made during a transfer only takes effect at the next enable. A three-state machine produces the timing:

- `ST_IDLE` moves to `ST_LOW` when `run` is sampled high.
- `ST_LOW` moves to `ST_HIGH` when its phase counter reaches the low length.
- `ST_HIGH` moves back to `ST_LOW` when its phase counter reaches the high length.
- Both `ST_LOW` and `ST_HIGH` return to `ST_IDLE` as soon as `run` is sampled low.

Every entry into a phase clears the counter. The first period after an enable therefore always has its full length.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, `sclk`, `sclk_rise` and `sclk_fall` are all 0.
- R2: In any cycle that follows a clock edge at which `run` was sampled low, `sclk` is 0 and neither strobe is asserted. This holds whatever configuration is written.
- R3: The period count is in bits 5:0 (P) and the high count is in bits 11:6 (H). When P is nonzero and H < P, one SCLK period lasts P+1 input cycles, and SCLK is high for H+1 of them.
- R4: After `run` is sampled high, SCLK starts with a full low phase of P−H cycles, beginning in the very next cycle, and then a high phase. Low and high phases then alternate.
- R5: `sclk_rise` is high for exactly the first cycle of each high phase. `sclk_fall` is high for exactly the first cycle of each low phase that follows a high phase. Leaving idle gives no fall strobe.
- R6: When P is 0, the period comes from the divider field in bits 17:12 (n, with n=0 treated as 1). The high count is then ((n+1)/2)−1, using integer division.
- R7: When H ≥ P, the high count is clamped to P−1. SCLK is then high for P cycles and low for 1 cycle.
- R8: A configuration write made while `run` is high does not change the running waveform or `src_sel`. The new value applies from the next enable.
- R9: When `run` is sampled low mid-transfer, even during a high phase, `sclk` is 0 in the next cycle and no strobe is produced.
- R10: `src_sel` shows bit 31 of the configuration in use. It follows writes only while `run` is low.
- R11: The fastest setting, P=1 with H=0, gives a two-cycle period: one cycle high and one cycle low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transfer enable; low forces idle |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word (period, high, divider, source select) |
| sclk | output | 1 | Serial clock, idle low |
| sclk_rise | output | 1 | One-cycle strobe in the first high cycle of SCLK |
| sclk_fall | output | 1 | One-cycle strobe in the first low cycle after a high phase |
| src_sel | output | 1 | Clock-source select bit of the configuration in use |

## Verification
A stray state or phase count shows at `sclk` within a single SCLK period. It appears as a phase that is one cycle too long or too short, or as a strobe that lands off the edge. The bench compares every cycle of several periods against an independently computed waveform. A configuration that was latched wrongly, or released early, shows in the first period after enable: the low and high lengths no longer match the word that was in force when `run` was last low. An exit from idle that was skipped or delayed shows in the first cycle after `run` changes.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    // Width of each count field in the configuration word
    localparam int CNT_W = 6;
    // Width of the configuration word
    localparam int REG_W = 32;

    // Phase of the serial clock
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_phase_e;

endpackage

// File: rtl/sclk_cfg_reg.sv
// Holds the written configuration and a frozen copy for the running transfer.
module sclk_cfg_reg #(
    parameter int CNT_W = spi_sclk_pkg::CNT_W,
    parameter int REG_W = spi_sclk_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] per_cnt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] div_cnt,
    output logic             src_sel
);
    localparam int PER_LSB = 0;
    localparam int HI_LSB  = CNT_W;
    localparam int DIV_LSB = 2 * CNT_W;
    localparam int FLD_END = 3 * CNT_W;
    localparam int SRC_BIT = REG_W - 1;

    // Written copy: tracks every write
    logic [CNT_W-1:0] wr_per_q, wr_hi_q, wr_div_q;
    logic             wr_src_q;
    // Copy in use: follows the newest value only while run is low
    logic [CNT_W-1:0] act_per_q, act_hi_q, act_div_q;
    logic             act_src_q;

    logic [CNT_W-1:0] new_per, new_hi, new_div;
    logic             new_src;
    logic             unused_rsvd;

    assign unused_rsvd = ^cfg_wdata[SRC_BIT-1:FLD_END];

    always_comb begin
        if (cfg_wr) begin
            new_per = cfg_wdata[PER_LSB +: CNT_W];
            new_hi  = cfg_wdata[HI_LSB  +: CNT_W];
            new_div = cfg_wdata[DIV_LSB +: CNT_W];
            new_src = cfg_wdata[SRC_BIT];
        end else begin
            new_per = wr_per_q;
            new_hi  = wr_hi_q;
            new_div = wr_div_q;
            new_src = wr_src_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_per_q <= '0;
            wr_hi_q  <= '0;
            wr_div_q <= '0;
            wr_src_q <= 1'b0;
        end else if (cfg_wr) begin
            wr_per_q <= new_per;
            wr_hi_q  <= new_hi;
            wr_div_q <= new_div;
            wr_src_q <= new_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_per_q <= '0;
            act_hi_q  <= '0;
            act_div_q <= '0;
            act_src_q <= 1'b0;
        end else if (!run) begin
            act_per_q <= new_per;
            act_hi_q  <= new_hi;
            act_div_q <= new_div;
            act_src_q <= new_src;
        end
    end

    assign per_cnt = act_per_q;
    assign hi_cnt  = act_hi_q;
    assign div_cnt = act_div_q;
    assign src_sel = act_src_q;

endmodule

// File: rtl/sclk_len_decode.sv
// Turns the count fields into terminal counts for the low and high phases.
module sclk_len_decode #(
    parameter int CNT_W = spi_sclk_pkg::CNT_W
) (
    input  logic [CNT_W-1:0] per_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] div_cnt,
    output logic [CNT_W-1:0] low_last,
    output logic [CNT_W-1:0] high_last
);
    localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W:0]   ONE_W = {{CNT_W{1'b0}}, 1'b1};

    logic             use_div;
    logic [CNT_W-1:0] p_sel, p_eff, h_sel, h_eff, h_div;
    logic [CNT_W:0]   p_inc;

    always_comb begin
        use_div = (per_cnt == '0);
        p_sel   = use_div ? div_cnt : per_cnt;
        p_eff   = (p_sel == '0) ? ONE : p_sel;
        p_inc   = {1'b0, p_eff} + ONE_W;
        h_div   = p_inc[CNT_W:1] - ONE;
        h_sel   = use_div ? h_div : hi_cnt;
        h_eff   = (h_sel >= p_eff) ? (p_eff - ONE) : h_sel;
        low_last  = p_eff - h_eff - ONE;
        high_last = h_eff;
    end

endmodule

// File: rtl/sclk_phase_fsm.sv
// Phase state machine: counts each phase and drives SCLK and its strobes.
module sclk_phase_fsm #(
    parameter int CNT_W = spi_sclk_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] low_last,
    input  logic [CNT_W-1:0] high_last,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall
);
    import spi_sclk_pkg::*;

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    sclk_phase_e      state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             sclk_q, rise_q, fall_q;

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q + ONE;
        unique case (state_q)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (run) begin
                    state_nxt = ST_LOW;
                end
            end
            ST_LOW: begin
                if (!run) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt_q == low_last) begin
                    state_nxt = ST_HIGH;
                    cnt_nxt   = '0;
                end
            end
            ST_HIGH: begin
                if (!run) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt_q == high_last) begin
                    state_nxt = ST_LOW;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            sclk_q <= (state_nxt == ST_HIGH);
            rise_q <= (state_nxt == ST_HIGH) && (state_q == ST_LOW);
            fall_q <= (state_nxt == ST_LOW) && (state_q == ST_HIGH);
        end
    end

    assign sclk      = sclk_q;
    assign sclk_rise = rise_q;
    assign sclk_fall = fall_q;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int CNT_W = spi_sclk_pkg::CNT_W,
    parameter int REG_W = spi_sclk_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             sclk,
    output logic             sclk_rise,
    output logic             sclk_fall,
    output logic             src_sel
);
    logic [CNT_W-1:0] per_cnt, hi_cnt, div_cnt;
    logic [CNT_W-1:0] low_last, high_last;

    sclk_cfg_reg #(.CNT_W(CNT_W), .REG_W(REG_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .per_cnt   (per_cnt),
        .hi_cnt    (hi_cnt),
        .div_cnt   (div_cnt),
        .src_sel   (src_sel)
    );

    sclk_len_decode #(.CNT_W(CNT_W)) dec_i (
        .per_cnt   (per_cnt),
        .hi_cnt    (hi_cnt),
        .div_cnt   (div_cnt),
        .low_last  (low_last),
        .high_last (high_last)
    );

    sclk_phase_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .low_last  (low_last),
        .high_last (high_last),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
    parameter int CNT_W = spi_sclk_pkg::CNT_W
) (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sclk,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic src_sel
);
    localparam logic [CNT_W:0] HMAX  = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] ONE_W = {{CNT_W{1'b0}}, 1'b1};

    // Consecutive high cycles seen up to the previous cycle
    logic [CNT_W:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (sclk) begin
            hi_run_q <= (hi_run_q == HMAX) ? HMAX : hi_run_q + ONE_W;
        end else begin
            hi_run_q <= '0;
        end
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (!sclk && !sclk_rise && !sclk_fall));

    a_r5_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |-> (sclk && !$past(sclk)));

    a_r5_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |-> (!sclk && $past(sclk)));

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));

    a_r8_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(src_sel));

    a_r3_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_run_q == HMAX) |-> !sclk);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .src_sel   (src_sel)
);

// File: tb/spi_sclk_gen_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb_top;

    logic        clk;
    logic        rst_n;
    logic        run;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic        sclk, sclk_rise, sclk_fall, src_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    spi_sclk_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .sclk      (sclk),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .src_sel   (src_sel)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic write_cfg(input logic [31:0] val);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Enables the clock and compares every cycle with the expected low/high
    // lengths; optionally writes a new word mid-run; then stops and checks idle.
    task automatic run_pattern(input bit pre_wr, input logic [31:0] cfg,
                               input int lo, input int hi, input int ncyc,
                               input bit mid_wr, input logic [31:0] mid_val,
                               input string req);
        int bad_s = 0, bad_r = 0, bad_f = 0;
        int fs_a = 0, fs_e = 0, fr_a = 0, fr_e = 0, ff_a = 0, ff_e = 0;
        if (pre_wr) write_cfg(cfg);
        @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < ncyc; k++) begin
            int idx;
            bit es, er, ef;
            @(negedge clk);
            idx = k % (lo + hi);
            es  = (idx >= lo);
            er  = (idx == lo);
            ef  = (idx == 0) && (k > 0);
            if (sclk !== es && bad_s == 0) begin fs_a = int'(sclk); fs_e = int'(es); end
            if (sclk_rise !== er && bad_r == 0) begin fr_a = int'(sclk_rise); fr_e = int'(er); end
            if (sclk_fall !== ef && bad_f == 0) begin ff_a = int'(sclk_fall); ff_e = int'(ef); end
            if (sclk !== es) bad_s++;
            if (sclk_rise !== er) bad_r++;
            if (sclk_fall !== ef) bad_f++;
            if (mid_wr && k == 2) begin cfg_wr = 1'b1; cfg_wdata = mid_val; end
            if (mid_wr && k == 3) cfg_wr = 1'b0;
        end
        chk(bad_s == 0, req, "sclk waveform", fs_a, fs_e);
        chk(bad_r == 0, req, "rise strobe (R5)", fr_a, fr_e);
        chk(bad_f == 0, req, "fall strobe (R5)", ff_a, ff_e);
        run    = 1'b0;
        cfg_wr = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0 && sclk_rise == 1'b0 && sclk_fall == 1'b0, "R9",
            "outputs after stop", int'({sclk, sclk_rise, sclk_fall}), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sclk == 1'b0 && sclk_rise == 1'b0 && sclk_fall == 1'b0, "R1",
            "outputs after reset", int'({sclk, sclk_rise, sclk_fall}), 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        write_cfg(32'h0000_0085);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sclk || sclk_rise || sclk_fall) seen++;
        end
        chk(seen == 0, "R2", "activity while idle", seen, 0);
    endtask

    task automatic t_src();
        write_cfg(32'h8000_0085);
        chk(src_sel == 1'b1, "R10", "src_sel after idle write", int'(src_sel), 1);
        @(negedge clk);
        run = 1'b1;
        write_cfg(32'h0000_0085);
        repeat (3) @(negedge clk);
        chk(src_sel == 1'b1, "R8", "src_sel after write during run", int'(src_sel), 1);
        run = 1'b0;
        @(negedge clk);
        chk(src_sel == 1'b0, "R10", "src_sel after stop", int'(src_sel), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        run       = 1'b0;
        cfg_wr    = 1'b0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        // R3 / R4: period 6, high 3
        run_pattern(1, 32'h0000_0085, 3, 3, 24, 0, '0, "R4");
        // R3: period 10, high 2
        run_pattern(1, 32'h0000_0049, 8, 2, 30, 0, '0, "R3");
        // R11: fastest
        run_pattern(1, 32'h0000_0001, 1, 1, 10, 0, '0, "R11");
        // R6: divider fallback, n=7, n=4, n=0
        run_pattern(1, 32'h0000_7000, 4, 4, 24, 0, '0, "R6");
        run_pattern(1, 32'h0000_4000, 3, 2, 20, 0, '0, "R6");
        run_pattern(1, 32'h0000_0000, 1, 1, 8, 0, '0, "R6");
        // R7: high count clamp
        run_pattern(1, 32'h0000_0284, 1, 4, 20, 0, '0, "R7");
        // R3: longest period
        run_pattern(1, 32'h0000_07FF, 32, 32, 130, 0, '0, "R3");
        // R8: write during run ignored, then used at next enable
        run_pattern(1, 32'h0000_0043, 2, 2, 16, 1, 32'h0000_0109, "R8");
        run_pattern(0, '0, 5, 5, 20, 0, '0, "R8");
        // R9: stop during the first high cycle
        run_pattern(1, 32'h0000_0085, 3, 3, 4, 0, '0, "R9");
        t_src();
        done = 1;
        report();
        $finish;
    end

endmodule